// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

A byte-wide shift unit for an SPI-style link with one serial data output, one serial data input and a serial clock. The serial clock comes from one of two sources. A remote master can drive the clock pin, and the unit then synchronizes and edge-detects it in the system clock domain. Otherwise local software makes the clock itself: each toggle strobe inverts the local clock output. Every strobe counts as one serial clock edge.

On one edge of each serial clock pulse the unit captures the input bit. On the opposite edge it shifts the register most-significant-bit first, so the output pin changes. A selectable edge mode swaps these two roles. The host loads the byte to send into the data register before the transfer. It clears the edge counter and the overflow flag together with a single clear pulse. Then it waits for the flag, which marks 16 counted edges (eight pulses). At that point the data register holds the received byte. A maskable interrupt follows the flag.

Top module: `tw_shift_unit`

## Requirements
- R1: After reset the edge counter is 0, the overflow flag and interrupt are low, the data register is 0 (so the data output is 0), and the local clock output is low.
- R2: With edge_mode = 0, the data input is captured on each rising serial clock edge and the register shifts left on each falling edge. The captured bit enters bit 0. After 16 edges the register holds the received byte, with its first received bit in bit 7.
- R3: With edge_mode = 1 the roles swap: capture happens on falling edges and shift on rising edges. A transfer in this mode starts from a high clock level.
- R4: The 4-bit edge counter increments by one on every edge of the selected clock source, rising and falling alike, and holds its value when no edge occurs.
- R5: When the counter wraps from 15 to 0, the overflow flag is set.
- R6: The overflow flag stays set until a stat_clr pulse. stat_clr forces both the counter and the flag to 0, even when an edge arrives in the same cycle.
- R7: irq is high exactly when the overflow flag is set and irq_en is 1.
- R8: With clk_src = 1, each toggle_stb inverts sclk_out and counts as one edge. A low-to-high inversion is a rising edge. Activity on sclk_in is ignored in this mode.
- R9: sdo always shows bit 7 of the data register. A write loads all eight bits, and a write takes priority over a shift in the same cycle.
- R10: With clk_src = 0, toggle_stb has no effect on sclk_out or on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data_en | input | 1 | Load the data register from wr_data |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Current data register contents (received byte after overflow) |
| edge_mode | input | 1 | 0: capture on rising edge, shift on falling; 1: swapped |
| clk_src | input | 1 | 0: external serial clock pin; 1: local toggle strobe |
| toggle_stb | input | 1 | Inverts the local serial clock (local source only) |
| stat_clr | input | 1 | Clears the edge counter and the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| sclk_in | input | 1 | Serial clock from a remote master |
| sdi | input | 1 | Serial data input |
| sclk_out | output | 1 | Locally generated serial clock |
| sdo | output | 1 | Serial data output |
| edge_cnt | output | 4 | Edge counter value |
| ovf_flag | output | 1 | Overflow flag, set after 16 edges |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are those where a counted edge falls in the same system cycle as a clear or a register write. An edge on the external clock pin appears only after the synchronizer delay. The stimulus therefore uses the local strobe source for these cases, because there a strobe is counted in the very cycle it is sampled. A strobe is driven together with stat_clr, or together with wr_data_en on a falling (shift) edge, and the bench checks that the clear and the load win. The edge mode 1 transfer is a second hard case. It needs the external clock parked high before the clear, so that the edge used to park the clock does not corrupt the transfer.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic {
    LEAD_CAPTURE = 1'b0,
    LEAD_SHIFT   = 1'b1
  } edge_mode_e;

  typedef enum logic {
    SRC_PIN    = 1'b0,
    SRC_STROBE = 1'b1
  } clk_src_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_ev_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/tws_clk_src.sv
module tws_clk_src
  import tws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     toggle_stb,
  input  logic     sclk_sync,
  output logic     sclk_out,
  output sclk_ev_t ev
);

  logic sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              sclk_out <= 1'b0;
    else if (src == SRC_STROBE && toggle_stb) sclk_out <= ~sclk_out;
  end

  always_comb begin
    if (src == SRC_STROBE) begin
      ev.rise = toggle_stb & ~sclk_out;
      ev.fall = toggle_stb &  sclk_out;
    end else begin
      ev.rise =  sclk_sync & ~sclk_prev;
      ev.fall = ~sclk_sync &  sclk_prev;
    end
  end

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          capture_ev,
  input  logic          shift_ev,
  input  logic          din,
  output logic [DW-1:0] shreg,
  output logic          dout
);

  logic held_bit;

  function automatic logic [DW-1:0] shift_in(input logic [DW-1:0] cur, input logic b);
    return {cur[DW-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held_bit <= 1'b0;
    else if (capture_ev) held_bit <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg <= '0;
    else if (load)     shreg <= load_data;
    else if (shift_ev) shreg <= shift_in(shreg, held_bit);
  end

  assign dout = shreg[DW-1];

endmodule

// File: rtl/tws_edge_counter.sv
module tws_edge_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          ovf
);

  logic wrap;

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  assign wrap = step && (cnt == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt_next(cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ovf <= 1'b0;
    else if (clr)   ovf <= 1'b0;
    else if (wrap)  ovf <= 1'b1;
  end

endmodule

// File: rtl/tw_shift_unit.sv
module tw_shift_unit
  import tws_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(2 * DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          edge_mode,
  input  logic          clk_src,
  input  logic          toggle_stb,
  input  logic          stat_clr,
  input  logic          irq_en,
  input  logic          sclk_in,
  input  logic          sdi,
  output logic          sclk_out,
  output logic          sdo,
  output logic [CW-1:0] edge_cnt,
  output logic          ovf_flag,
  output logic          irq
);

  logic [1:0] pins_sync;
  logic       sclk_sync;
  logic       sdi_sync;
  sclk_ev_t   sclk_ev;
  logic       edge_ev;
  logic       sample_ev;
  logic       shift_ev;
  edge_mode_e mode;
  clk_src_e   src;

  assign mode = edge_mode_e'(edge_mode);
  assign src  = clk_src_e'(clk_src);

  tws_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_in, sdi}),
    .q     (pins_sync)
  );

  assign sclk_sync = pins_sync[1];
  assign sdi_sync  = pins_sync[0];

  tws_clk_src u_clk_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .toggle_stb (toggle_stb),
    .sclk_sync  (sclk_sync),
    .sclk_out   (sclk_out),
    .ev         (sclk_ev)
  );

  assign edge_ev   = sclk_ev.rise | sclk_ev.fall;
  assign sample_ev = (mode == LEAD_CAPTURE) ? sclk_ev.rise : sclk_ev.fall;
  assign shift_ev  = (mode == LEAD_CAPTURE) ? sclk_ev.fall : sclk_ev.rise;

  tws_shifter #(.DW(DW)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wr_data_en),
    .load_data  (wr_data),
    .capture_ev (sample_ev),
    .shift_ev   (shift_ev),
    .din        (sdi_sync),
    .shreg      (rd_data),
    .dout       (sdo)
  );

  tws_edge_counter #(.CW(CW)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stat_clr),
    .step  (edge_ev),
    .cnt   (edge_cnt),
    .ovf   (ovf_flag)
  );

  assign irq = ovf_flag & irq_en;

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stat_clr,
  input logic          edge_ev,
  input logic [CW-1:0] edge_cnt,
  input logic          ovf_flag,
  input logic          wr_data_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          clk_src,
  input logic          toggle_stb,
  input logic          sclk_out,
  input logic          sample_ev,
  input logic          shift_ev
);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev && !stat_clr) |=> edge_cnt == CW'($past(edge_cnt) + 1'b1));

  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_ev && !stat_clr) |=> $stable(edge_cnt));

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev && !stat_clr && edge_cnt == {CW{1'b1}}) |=> ovf_flag);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !stat_clr) |=> ovf_flag);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (edge_cnt == '0 && !ovf_flag));

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> rd_data == $past(wr_data));

  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src && toggle_stb) |=> sclk_out != $past(sclk_out));

  p_pin_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_src |=> $stable(sclk_out));

  p_roles_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_ev, shift_ev}));

endmodule

bind tw_shift_unit tws_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stat_clr   (stat_clr),
  .edge_ev    (edge_ev),
  .edge_cnt   (edge_cnt),
  .ovf_flag   (ovf_flag),
  .wr_data_en (wr_data_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .clk_src    (clk_src),
  .toggle_stb (toggle_stb),
  .sclk_out   (sclk_out),
  .sample_ev  (sample_ev),
  .shift_ev   (shift_ev)
);

// File: tb/tw_shift_unit_bench.sv
module tw_shift_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_data_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       edge_mode;
  logic       clk_src;
  logic       toggle_stb;
  logic       stat_clr;
  logic       irq_en;
  logic       sclk_in;
  logic       sdi;
  logic       sclk_out;
  logic       sdo;
  logic [3:0] edge_cnt;
  logic       ovf_flag;
  logic       irq;

  typedef struct {
    string      tag;
    logic [7:0] val;
  } exp_item_t;

  exp_item_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tw_shift_unit u_tw_shift_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .edge_mode  (edge_mode),
    .clk_src    (clk_src),
    .toggle_stb (toggle_stb),
    .stat_clr   (stat_clr),
    .irq_en     (irq_en),
    .sclk_in    (sclk_in),
    .sdi        (sdi),
    .sclk_out   (sclk_out),
    .sdo        (sdo),
    .edge_cnt   (edge_cnt),
    .ovf_flag   (ovf_flag),
    .irq        (irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_and_load(logic [7:0] tx);
    stat_clr   = 1'b1;
    wr_data_en = 1'b1;
    wr_data    = tx;
    tick(1);
    stat_clr   = 1'b0;
    wr_data_en = 1'b0;
  endtask

  task automatic pulse_strobe();
    toggle_stb = 1'b1;
    tick(1);
    toggle_stb = 1'b0;
  endtask

  task automatic pin_edge(logic level);
    sclk_in = level;
    tick(4);
  endtask

  // external-clock transfer; mode 1 starts from a parked-high clock (R3)
  task automatic pin_xfer(logic [7:0] tx, logic [7:0] rx, logic mode, string tag);
    clk_src   = 1'b0;
    edge_mode = mode;
    pin_edge(mode);
    clear_and_load(tx);
    exp_q.push_back('{tag, rx});
    for (int i = 0; i < 8; i++) begin
      sdi = rx[7-i];
      chk({tag, " sdo bit (R9)"}, sdo, tx[7-i]);
      pin_edge(~mode);
      pin_edge(mode);
    end
    tick(2);
    chk("R5 overflow after 16 edges", ovf_flag, 1);
    chk("R4 counter wrapped to 0", edge_cnt, 0);
  endtask

  task automatic local_xfer(logic [7:0] tx, logic [7:0] rx);
    clk_src   = 1'b1;
    edge_mode = 1'b0;
    clear_and_load(tx);
    exp_q.push_back('{"R8", rx});
    for (int i = 0; i < 8; i++) begin
      sdi = rx[7-i];
      tick(4);
      chk("R8 sdo bit", sdo, tx[7-i]);
      pulse_strobe();
      chk("R8 strobe raises sclk_out", sclk_out, 1);
      tick(3);
      pulse_strobe();
      chk("R8 strobe lowers sclk_out", sclk_out, 0);
      tick(3);
    end
    chk("R5 overflow after 16 strobes", ovf_flag, 1);
  endtask

  // monitor: compare received byte on each overflow
  initial begin
    forever begin
      @(posedge ovf_flag);
      @(negedge clk);
      if (exp_q.size() == 0) chk("R5 unexpected overflow", 1, 0);
      else begin
        exp_item_t it;
        it = exp_q.pop_front();
        chk({it.tag, " received byte"}, rd_data, it.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic       so_before;
    logic [3:0] cnt_before;
    rst_n = 1'b0; wr_data_en = 1'b0; wr_data = '0; edge_mode = 1'b0;
    clk_src = 1'b0; toggle_stb = 1'b0; stat_clr = 1'b0; irq_en = 1'b0;
    sclk_in = 1'b0; sdi = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 counter", edge_cnt, 0);
    chk("R1 overflow", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 sclk_out", sclk_out, 0);

    pin_xfer(8'h96, 8'h3C, 1'b0, "R2");
    chk("R7 irq masked", irq, 0);
    irq_en = 1'b1;
    tick(1);
    chk("R7 irq enabled", irq, 1);
    pin_edge(1'b1);
    pin_edge(1'b0);
    chk("R6 flag sticky", ovf_flag, 1);
    chk("R4 counts past wrap", edge_cnt, 2);
    stat_clr = 1'b1; tick(1); stat_clr = 1'b0;
    chk("R6 clear counter", edge_cnt, 0);
    chk("R6 clear flag", ovf_flag, 0);
    chk("R7 irq drops", irq, 0);
    irq_en = 1'b0;

    pin_edge(1'b1); pin_edge(1'b0); pin_edge(1'b1); pin_edge(1'b0); pin_edge(1'b1);
    chk("R4 five edges", edge_cnt, 5);
    pin_edge(1'b0);
    chk("R4 six edges", edge_cnt, 6);

    pin_xfer(8'h5A, 8'hC3, 1'b1, "R3");
    pin_xfer(8'h00, 8'hFF, 1'b0, "R2");
    pin_xfer(8'hFF, 8'h00, 1'b0, "R2");
    pin_edge(1'b0);

    // R10: strobe ignored on pin source
    clk_src    = 1'b0;
    so_before  = sclk_out;
    cnt_before = edge_cnt;
    pulse_strobe();
    tick(2);
    chk("R10 sclk_out unchanged", sclk_out, so_before);
    chk("R10 counter unchanged", edge_cnt, cnt_before);

    local_xfer(8'hE1, 8'h7E);

    // R8: pin activity ignored on strobe source
    clk_src = 1'b1;
    stat_clr = 1'b1; tick(1); stat_clr = 1'b0;
    pin_edge(1'b1);
    pin_edge(1'b0);
    chk("R8 pin edges ignored", edge_cnt, 0);

    // R6: clear beats a simultaneous edge
    pulse_strobe();
    chk("R4 strobe counted", edge_cnt, 1);
    toggle_stb = 1'b1; stat_clr = 1'b1;
    tick(1);
    toggle_stb = 1'b0; stat_clr = 1'b0;
    chk("R6 clear wins counter", edge_cnt, 0);
    chk("R6 clear wins flag", ovf_flag, 0);

    // R9: write beats a simultaneous shift
    pulse_strobe();
    toggle_stb = 1'b1; wr_data_en = 1'b1; wr_data = 8'hA5;
    tick(1);
    toggle_stb = 1'b0; wr_data_en = 1'b0;
    chk("R9 write wins over shift", rd_data, 8'hA5);
    chk("R9 sdo shows msb", sdo, 1);

    tick(4);
    chk("R5 no pending transfers", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule